// File: doc/BRIEF.md
# Two-Address Processor Control Unit

This block is the sequencing controller of a small two-address processor. It repeats a wait, fetch and execute cycle on 20-bit instruction words. In the wait state it holds until the datapath reports that it is idle. In single-step mode it also needs a one-cycle step pulse. The fetch cycle reads the word at the program counter into the instruction register. The execute cycle decodes that word and, for exactly one cycle, drives the register selects, the ALU function code, the immediate operand, the memory strobes and the I/O strobes. At the end of the execute cycle the program counter is updated.

The ALU, the register file, the memory array and the display logic sit outside this block. Memory reads are combinational: during the fetch cycle, `mem_rdata_i` must carry the word at `mem_addr_o`. Condition flags come back on `flag_z_i` and `flag_n_i` and are sampled in the execute cycle of a branch. Register numbers 14 and 15 stand for the program counter and the instruction register. In this block both live here and are also visible on `pc_o` and `ir_o`.

Instruction fields: bits [19:18] give the class and bits [17:16] the operation. Branch and memory words carry a 9-bit address in [15:7]. Memory words carry their register in [6:3]. ALU words carry cc in [15] and the operand form in [14]. The register form has source [13:10] and destination [9:6]. The immediate form has destination [13:10] and a 10-bit immediate [9:0]. I/O words carry their register in [15:12].

Top module: `tap_ctrl`

## Requirements
- R1: While `rst_ni` is low and right after it rises: `pc_o` is 0, `halted_o` is 0, `exec_o` and `mem_ld_o` are 0, and `alu_fn_o` is 3'b111.
- R2: A fetch cycle (`mem_ld_o`=1 with `exec_o`=0 and `mem_addr_o`=`pc_o`) begins only in the cycle after one in which `ack_i` was high. While `ack_i` stays low, no fetch happens.
- R3: While `dbg_en_i` is high, a fetch begins only in the cycle after a cycle with `dbg_step_i` high. Each pulse runs exactly one instruction.
- R4: Every fetch cycle is followed directly by one execute cycle (`exec_o`=1). In that cycle `pc_o` still holds the address of the executing word. Except for a taken branch or halt, `pc_o` then advances by 1.
- R5: Class 00 is a branch. Op 00 is always taken, 01 is taken if `flag_z_i`, 10 is taken if not `flag_z_i`, and 11 is taken if `flag_n_i`. A taken branch loads bits [15:7] into `pc_o`.
- R6: Class 01 is a memory transfer on address [15:7] with register [6:3] on both `rf_a_o` and `rf_d_o`. Op 00 loads a word, 01 stores a word, 10 loads a byte and 11 stores a byte. `mem_byte_o` follows op bit 1. Loads also raise `rf_we_o`.
- R7: In the class 10 immediate form (bit 14 = 0), `rf_a_o` and `rf_d_o` both select [13:10], `alu_imm_sel_o` is 1, `imm_o` is [9:0] sign-extended to 32 bits, and `rf_we_o` is 1.
- R8: In the class 10 register form (bit 14 = 1), `rf_a_o` selects [13:10], `rf_d_o` selects [9:6], `alu_imm_sel_o` is 0, and `rf_we_o` is 1.
- R9: `alu_fn_o` is {cc, op} for op 00 AND, 01 OR and 10 ADD, and `flag_we_o` equals cc. Op 11, shift right, gives `alu_fn_o`=3'b011 and `flag_we_o`=0 whatever cc is.
- R10: In class 11, op 00 raises `disp_we_o` with register [15:12] selected. Op 01 raises `sw_rd_o` and `rf_we_o` with destination [15:12]. Any other class 11 word that is not halt does nothing but advance the program counter.
- R11: The word 20'hFFFFF halts the controller. After its execute cycle, `halted_o` stays high, `pc_o` holds the address of the halt, and no fetch or execute cycle occurs until reset.
- R12: Outside an execute cycle, `alu_fn_o` is 3'b111 and `rf_we_o`, `mem_st_o`, `disp_we_o`, `sw_rd_o` and `flag_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ack_i | input | 1 | Datapath idle acknowledge |
| dbg_en_i | input | 1 | Single-step mode enable |
| dbg_step_i | input | 1 | One-cycle step pulse |
| flag_z_i | input | 1 | Zero flag from the ALU |
| flag_n_i | input | 1 | Negative flag from the ALU |
| mem_rdata_i | input | 20 | Instruction word read from memory |
| mem_addr_o | output | 9 | Memory address |
| mem_ld_o | output | 1 | Memory read strobe |
| mem_st_o | output | 1 | Memory write strobe |
| mem_byte_o | output | 1 | Byte-wide transfer |
| rf_a_o | output | 4 | First operand / source register select |
| rf_d_o | output | 4 | Destination register select |
| rf_we_o | output | 1 | Register write enable |
| alu_fn_o | output | 3 | ALU function code |
| alu_imm_sel_o | output | 1 | Second ALU operand is the immediate |
| imm_o | output | 32 | Sign-extended immediate |
| flag_we_o | output | 1 | Condition flag update enable |
| disp_we_o | output | 1 | Load display from selected register |
| sw_rd_o | output | 1 | Write switch value into selected register |
| exec_o | output | 1 | Execute cycle marker |
| pc_o | output | 9 | Program counter |
| ir_o | output | 20 | Instruction register |
| halted_o | output | 1 | Controller halted |

## Verification
The assertions check the cycle-level rules on every cycle:
- A fetch must be preceded by an acknowledge and, in step mode, by a step pulse.
- A fetch is always followed by an execute cycle.
- After an ALU word the program counter advances by one.
- A shift never requests a flag update.
- The halted state is permanent.
- No strobe or function code leaks outside an execute cycle.

Only the bench scenarios can show that each decoded field lands on the right port, that each branch condition picks the right target, that immediates are sign-extended correctly, and that the sequence of executed addresses matches the program.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [1:0] {ST_WAIT, ST_FETCH, ST_EXEC, ST_HALT} st_e;
  typedef enum logic [1:0] {CL_BR = 2'b00, CL_MEM = 2'b01, CL_ALU = 2'b10, CL_SYS = 2'b11} cls_e;
  localparam logic [2:0] FN_SHR  = 3'b011;
  localparam logic [2:0] FN_NONE = 3'b111;
  localparam logic [1:0] OP_SHR  = 2'b11;
endpackage

// File: rtl/tap_decode.sv
module tap_decode
  import tap_pkg::*;
#(
  parameter int IW = 20,
  parameter int AW = 9,
  parameter int RW = 4,
  parameter int DW = 32
) (
  input  logic [IW-1:0] ir_i,
  input  logic          z_i,
  input  logic          n_i,
  output logic          halt_o,
  output logic          taken_o,
  output logic [AW-1:0] tgt_o,
  output logic          ld_o,
  output logic          st_o,
  output logic          byte_o,
  output logic [RW-1:0] ra_o,
  output logic [RW-1:0] rd_o,
  output logic          we_o,
  output logic [2:0]    fn_o,
  output logic          imm_sel_o,
  output logic [DW-1:0] imm_o,
  output logic          flag_we_o,
  output logic          disp_o,
  output logic          sw_o
);
  localparam int OP2_LO = IW - 4;
  localparam int ADR_HI = IW - 5;
  localparam int ADR_LO = IW - 4 - AW;
  localparam int MRG_LO = ADR_LO - RW;
  localparam int CC_B   = IW - 5;
  localparam int RR_B   = IW - 6;
  localparam int R1_LO  = IW - 6 - RW;
  localparam int R2_LO  = R1_LO - RW;
  localparam int IMW    = R1_LO;
  localparam int SRG_LO = IW - 4 - RW;

  cls_e       cls;
  logic [1:0] op2;
  logic       cond;

  assign cls   = cls_e'(ir_i[IW-1:IW-2]);
  assign op2   = ir_i[IW-3:OP2_LO];
  assign tgt_o = ir_i[ADR_HI:ADR_LO];
  assign imm_o = {{(DW-IMW){ir_i[IMW-1]}}, ir_i[IMW-1:0]};

  always_comb begin
    unique case (op2)
      2'b00:   cond = 1'b1;
      2'b01:   cond = z_i;
      2'b10:   cond = ~z_i;
      default: cond = n_i;
    endcase
  end

  always_comb begin
    halt_o    = 1'b0;
    taken_o   = 1'b0;
    ld_o      = 1'b0;
    st_o      = 1'b0;
    byte_o    = 1'b0;
    ra_o      = '0;
    rd_o      = '0;
    we_o      = 1'b0;
    fn_o      = FN_NONE;
    imm_sel_o = 1'b0;
    flag_we_o = 1'b0;
    disp_o    = 1'b0;
    sw_o      = 1'b0;
    unique case (cls)
      CL_BR: taken_o = cond;
      CL_MEM: begin
        ra_o   = ir_i[ADR_LO-1:MRG_LO];
        rd_o   = ir_i[ADR_LO-1:MRG_LO];
        ld_o   = ~op2[0];
        st_o   = op2[0];
        byte_o = op2[1];
        we_o   = ~op2[0];
      end
      CL_ALU: begin
        we_o = 1'b1;
        if (op2 == OP_SHR) begin
          fn_o = FN_SHR;
        end else begin
          fn_o      = {ir_i[CC_B], op2};
          flag_we_o = ir_i[CC_B];
        end
        if (ir_i[RR_B]) begin
          ra_o = ir_i[R1_LO+RW-1:R1_LO];
          rd_o = ir_i[R2_LO+RW-1:R2_LO];
        end else begin
          ra_o      = ir_i[R1_LO+RW-1:R1_LO];
          rd_o      = ir_i[R1_LO+RW-1:R1_LO];
          imm_sel_o = 1'b1;
        end
      end
      default: begin
        unique case (op2)
          2'b00: begin
            disp_o = 1'b1;
            ra_o   = ir_i[ADR_HI:SRG_LO];
            rd_o   = ir_i[ADR_HI:SRG_LO];
          end
          2'b01: begin
            sw_o = 1'b1;
            we_o = 1'b1;
            ra_o = ir_i[ADR_HI:SRG_LO];
            rd_o = ir_i[ADR_HI:SRG_LO];
          end
          2'b11:   halt_o = &ir_i[ADR_HI:0];
          default: halt_o = 1'b0;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/tap_seq.sv
module tap_seq
  import tap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  input  logic dbg_en_i,
  input  logic dbg_step_i,
  input  logic halt_i,
  output logic fetch_o,
  output logic exec_o,
  output logic halted_o
);
  st_e  st_q, st_d;
  logic go;

  // step pulse only matters in the wait state
  assign go = ack_i & (~dbg_en_i | dbg_step_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_WAIT:  st_d = go ? ST_FETCH : ST_WAIT;
      ST_FETCH: st_d = ST_EXEC;
      ST_EXEC:  st_d = halt_i ? ST_HALT : ST_WAIT;
      default:  st_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_WAIT;
    else         st_q <= st_d;
  end

  assign fetch_o  = (st_q == ST_FETCH);
  assign exec_o   = (st_q == ST_EXEC);
  assign halted_o = (st_q == ST_HALT);
endmodule

// File: rtl/tap_pc.sv
module tap_pc #(
  parameter int AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          exec_i,
  input  logic          hold_i,
  input  logic          load_i,
  input  logic [AW-1:0] tgt_i,
  output logic [AW-1:0] pc_o
);
  logic [AW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (exec_i && !hold_i) begin
      pc_q <= load_i ? tgt_i : pc_q + AW'(1);
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
#(
  parameter int IW = 20,
  parameter int AW = 9,
  parameter int RW = 4,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ack_i,
  input  logic          dbg_en_i,
  input  logic          dbg_step_i,
  input  logic          flag_z_i,
  input  logic          flag_n_i,
  input  logic [IW-1:0] mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ld_o,
  output logic          mem_st_o,
  output logic          mem_byte_o,
  output logic [RW-1:0] rf_a_o,
  output logic [RW-1:0] rf_d_o,
  output logic          rf_we_o,
  output logic [2:0]    alu_fn_o,
  output logic          alu_imm_sel_o,
  output logic [DW-1:0] imm_o,
  output logic          flag_we_o,
  output logic          disp_we_o,
  output logic          sw_rd_o,
  output logic          exec_o,
  output logic [AW-1:0] pc_o,
  output logic [IW-1:0] ir_o,
  output logic          halted_o
);
  logic          fetch, exec;
  logic [IW-1:0] ir_q;
  logic [AW-1:0] pc;
  logic          d_halt, d_taken, d_ld, d_st, d_byte, d_we, d_isel, d_fwe, d_disp, d_sw;
  logic [AW-1:0] d_tgt;
  logic [RW-1:0] d_ra, d_rd;
  logic [2:0]    d_fn;
  logic [DW-1:0] d_imm;

  tap_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ack_i      (ack_i),
    .dbg_en_i   (dbg_en_i),
    .dbg_step_i (dbg_step_i),
    .halt_i     (d_halt),
    .fetch_o    (fetch),
    .exec_o     (exec),
    .halted_o   (halted_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ir_q <= '0;
    else if (fetch) ir_q <= mem_rdata_i;
  end

  tap_decode #(.IW(IW), .AW(AW), .RW(RW), .DW(DW)) u_dec (
    .ir_i      (ir_q),
    .z_i       (flag_z_i),
    .n_i       (flag_n_i),
    .halt_o    (d_halt),
    .taken_o   (d_taken),
    .tgt_o     (d_tgt),
    .ld_o      (d_ld),
    .st_o      (d_st),
    .byte_o    (d_byte),
    .ra_o      (d_ra),
    .rd_o      (d_rd),
    .we_o      (d_we),
    .fn_o      (d_fn),
    .imm_sel_o (d_isel),
    .imm_o     (d_imm),
    .flag_we_o (d_fwe),
    .disp_o    (d_disp),
    .sw_o      (d_sw)
  );

  tap_pc #(.AW(AW)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .exec_i (exec),
    .hold_i (d_halt),
    .load_i (d_taken),
    .tgt_i  (d_tgt),
    .pc_o   (pc)
  );

  assign mem_addr_o    = (exec && (d_ld || d_st)) ? d_tgt : pc;
  assign mem_ld_o      = fetch | (exec & d_ld);
  assign mem_st_o      = exec & d_st;
  assign mem_byte_o    = exec & d_byte;
  assign rf_a_o        = d_ra;
  assign rf_d_o        = d_rd;
  assign rf_we_o       = exec & d_we;
  assign alu_fn_o      = exec ? d_fn : FN_NONE;
  assign alu_imm_sel_o = exec & d_isel;
  assign imm_o         = d_imm;
  assign flag_we_o     = exec & d_fwe;
  assign disp_we_o     = exec & d_disp;
  assign sw_rd_o       = exec & d_sw;
  assign exec_o        = exec;
  assign pc_o          = pc;
  assign ir_o          = ir_q;
endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk #(
  parameter int IW = 20,
  parameter int AW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ack_i,
  input logic          dbg_en_i,
  input logic          dbg_step_i,
  input logic          mem_ld_o,
  input logic          mem_st_o,
  input logic          rf_we_o,
  input logic [2:0]    alu_fn_o,
  input logic          flag_we_o,
  input logic          disp_we_o,
  input logic          sw_rd_o,
  input logic          exec_o,
  input logic [AW-1:0] pc_o,
  input logic [IW-1:0] ir_o,
  input logic          halted_o
);
  logic fetch_c;
  assign fetch_c = mem_ld_o & ~exec_o;

  p_fetch_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_c |-> $past(ack_i));

  p_step_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_c && $past(dbg_en_i)) |-> $past(dbg_step_i));

  p_fetch_exec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_c |=> exec_o);

  p_pc_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && ir_o[IW-1:IW-2] == 2'b10) |=> pc_o == $past(pc_o) + AW'(1));

  p_shift_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && ir_o[IW-1:IW-4] == 4'b1011) |-> (!flag_we_o && alu_fn_o == 3'b011));

  p_halt_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && !mem_ld_o && !exec_o && $stable(pc_o)));

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_o |-> (alu_fn_o == 3'b111 && !rf_we_o && !mem_st_o && !flag_we_o
                 && !disp_we_o && !sw_rd_o));
endmodule

bind tap_ctrl tap_ctrl_chk #(.IW(IW), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_i      (ack_i),
  .dbg_en_i   (dbg_en_i),
  .dbg_step_i (dbg_step_i),
  .mem_ld_o   (mem_ld_o),
  .mem_st_o   (mem_st_o),
  .rf_we_o    (rf_we_o),
  .alu_fn_o   (alu_fn_o),
  .flag_we_o  (flag_we_o),
  .disp_we_o  (disp_we_o),
  .sw_rd_o    (sw_rd_o),
  .exec_o     (exec_o),
  .pc_o       (pc_o),
  .ir_o       (ir_o),
  .halted_o   (halted_o)
);

// File: tb/tap_ctrl_tb_top.sv
module tap_ctrl_tb_top;
  typedef struct packed {
    logic [8:0]  pc;
    logic [8:0]  maddr;
    logic        ld, st, mbyte, we, isel, fwe, disp, sw;
    logic [3:0]  ra, rd;
    logic [2:0]  fn;
    logic [31:0] imm;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ack = 1'b0, dbg_en = 1'b0, dbg_step = 1'b0, fz = 1'b0, fn_n = 1'b0;
  logic [19:0] rdata;
  logic [8:0]  maddr, pc;
  logic        ld, st, mbyte, we, isel, fwe, disp, sw, ex, halted;
  logic [3:0]  ra, rd;
  logic [2:0]  fn;
  logic [31:0] imm;
  logic [19:0] ir;
  logic [19:0] prog [512];

  int   n_chk = 0, n_fail = 0;
  exp_t q[$];
  string tq[$];

  always #5 clk = ~clk;

  assign rdata = prog[maddr];

  tap_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ack_i(ack), .dbg_en_i(dbg_en), .dbg_step_i(dbg_step),
    .flag_z_i(fz), .flag_n_i(fn_n), .mem_rdata_i(rdata), .mem_addr_o(maddr),
    .mem_ld_o(ld), .mem_st_o(st), .mem_byte_o(mbyte), .rf_a_o(ra), .rf_d_o(rd),
    .rf_we_o(we), .alu_fn_o(fn), .alu_imm_sel_o(isel), .imm_o(imm), .flag_we_o(fwe),
    .disp_we_o(disp), .sw_rd_o(sw), .exec_o(ex), .pc_o(pc), .ir_o(ir), .halted_o(halted)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] i_br(input logic [1:0] op, input logic [8:0] t);
    return {2'b00, op, t, 7'b0};
  endfunction
  function automatic logic [19:0] i_mem(input logic [1:0] op, input logic [8:0] a, input logic [3:0] r);
    return {2'b01, op, a, r, 3'b0};
  endfunction
  function automatic logic [19:0] i_alui(input logic [1:0] op, input logic cc, input logic [3:0] r, input logic [9:0] v);
    return {2'b10, op, cc, 1'b0, r, v};
  endfunction
  function automatic logic [19:0] i_alur(input logic [1:0] op, input logic cc, input logic [3:0] s, input logic [3:0] d);
    return {2'b10, op, cc, 1'b1, s, d, 6'b0};
  endfunction
  function automatic logic [19:0] i_sys(input logic [1:0] op, input logic [3:0] r);
    return {2'b11, op, r, 12'b0};
  endfunction

  // expected execute-cycle outputs, from the requirements
  function automatic exp_t model(input logic [19:0] w, input logic [8:0] p, input logic z, input logic n,
                                 output logic [8:0] np, output bit hlt, output string tag);
    exp_t e = '0;
    logic [1:0] op = w[17:16];
    e.pc = p; e.maddr = p; e.fn = 3'b111; np = p + 9'd1; hlt = 0; tag = "R10";
    case (w[19:18])
      2'b00: begin
        tag = "R5";
        if (op == 2'b00 || (op == 2'b01 && z) || (op == 2'b10 && !z) || (op == 2'b11 && n)) np = w[15:7];
      end
      2'b01: begin
        tag = "R6";
        e.maddr = w[15:7]; e.ra = w[6:3]; e.rd = w[6:3];
        e.ld = !op[0]; e.st = op[0]; e.mbyte = op[1]; e.we = !op[0];
      end
      2'b10: begin
        tag = w[14] ? "R8" : "R7";
        if (op == 2'b11) begin e.fn = 3'b011; tag = "R9"; end
        else begin e.fn = {w[15], op}; e.fwe = w[15]; end
        e.we = 1'b1;
        if (w[14]) begin e.ra = w[13:10]; e.rd = w[9:6]; end
        else begin
          e.ra = w[13:10]; e.rd = w[13:10]; e.isel = 1'b1;
          e.imm = {{22{w[9]}}, w[9:0]};
        end
      end
      default: begin
        if (op == 2'b00) begin e.disp = 1'b1; e.ra = w[15:12]; e.rd = w[15:12]; end
        else if (op == 2'b01) begin e.sw = 1'b1; e.we = 1'b1; e.ra = w[15:12]; e.rd = w[15:12]; end
        else if (w == 20'hFFFFF) begin hlt = 1; np = p; tag = "R11"; end
      end
    endcase
    return e;
  endfunction

  // driver: walk the program and push expected execute items
  task automatic run_prog(input logic z, input logic n);
    logic [8:0] p = '0, np;
    bit h;
    string t;
    fz = z; fn_n = n;
    for (int k = 0; k < 64; k++) begin
      q.push_back(model(prog[p], p, z, n, np, h, t));
      tq.push_back(t);
      if (h) break;
      p = np;
    end
  endtask

  // monitor: compare every execute cycle against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && ex) begin
      exp_t g, e;
      string t;
      g = '{pc: pc, maddr: maddr, ld: ld, st: st, mbyte: mbyte, we: we, isel: isel,
            fwe: fwe, disp: disp, sw: sw, ra: ra, rd: rd, fn: fn, imm: imm};
      if (q.size() == 0) begin
        chk(1'b0, "R4 unexpected execute", 64'(pc), 64'(0));
      end else begin
        e = q.pop_front();
        t = tq.pop_front();
        if (!e.isel) g.imm = '0;
        chk(g == e, t, 64'(g), 64'(e));
      end
    end
  end

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wait_halt(input logic [8:0] hpc);
    int c = 0;
    logic [8:0] p0;
    bit ok = 1;
    while (!halted && c < 3000) begin @(negedge clk); c++; end
    chk(halted, "R11 halt reached", 64'(halted), 64'(1));
    chk(q.size() == 0, "R4 all expected executes seen", 64'(q.size()), 64'(0));
    p0 = pc;
    chk(p0 == hpc, "R11 pc at halt", 64'(p0), 64'(hpc));
    repeat (16) begin
      @(negedge clk);
      if (!halted || ld || ex || pc != p0) ok = 0;
    end
    chk(ok, "R11 halt sticky", 64'(ok), 64'(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ok;
    for (int i = 0; i < 512; i++) prog[i] = '0;
    // R1: reset state
    @(negedge clk);
    chk(pc == 0 && !ld && !ex && !halted && fn == 3'b111, "R1 reset",
        {ld, ex, halted, fn, 46'(pc)}, {3'b000, 3'b111, 46'd0});
    rst_ni = 1'b1;
    @(negedge clk);
    chk(pc == 0 && !ld && !ex && !halted && fn == 3'b111, "R1 after reset",
        {ld, ex, halted, fn, 46'(pc)}, {3'b000, 3'b111, 46'd0});

    // program 1
    prog[0]  = i_alui(2'b10, 1'b1, 4'd3, 10'h3FB);
    prog[1]  = i_alur(2'b00, 1'b0, 4'd2, 4'd5);
    prog[2]  = i_alui(2'b11, 1'b1, 4'd4, 10'd1);
    prog[3]  = i_alur(2'b01, 1'b1, 4'd7, 4'd1);
    prog[4]  = i_mem(2'b00, 9'h1A0, 4'd6);
    prog[5]  = i_mem(2'b01, 9'h005, 4'd2);
    prog[6]  = i_mem(2'b10, 9'h0FF, 4'd9);
    prog[7]  = i_mem(2'b11, 9'h100, 4'd13);
    prog[8]  = i_sys(2'b00, 4'd2);
    prog[9]  = i_sys(2'b01, 4'd8);
    prog[10] = i_sys(2'b10, 4'd0);
    prog[11] = i_br(2'b01, 9'd20);
    prog[12] = i_br(2'b10, 9'd20);
    prog[20] = i_br(2'b11, 9'd30);
    prog[21] = i_br(2'b00, 9'd40);
    prog[40] = i_alui(2'b10, 1'b0, 4'd0, 10'h1FF);
    prog[41] = i_alur(2'b11, 1'b0, 4'd12, 4'd11);
    prog[42] = 20'hFFFFF;
    run_prog(1'b0, 1'b0);

    // R2: no fetch while acknowledge is low
    ok = 1;
    repeat (8) begin @(negedge clk); if (ld || ex) ok = 0; end
    chk(ok, "R2 no fetch without ack", 64'(ok), 64'(1));
    ack = 1'b1;
    wait_halt(9'd42);

    // program 2: branch conditions with both flags set
    ack = 1'b0;
    do_reset();
    prog[0]  = i_br(2'b01, 9'd50);
    prog[50] = i_br(2'b10, 9'd60);
    prog[51] = i_br(2'b11, 9'd70);
    prog[70] = 20'hFFFFF;
    run_prog(1'b1, 1'b1);
    ack = 1'b1;
    wait_halt(9'd70);

    // program 3: single-step mode
    dbg_en = 1'b1;
    do_reset();
    prog[0] = i_alui(2'b10, 1'b1, 4'd11, 10'h200);
    prog[1] = 20'hFFFFF;
    run_prog(1'b0, 1'b0);
    ok = 1;
    repeat (10) begin @(negedge clk); if (ld || ex) ok = 0; end
    chk(ok, "R3 waits for step", 64'(ok), 64'(1));
    dbg_step = 1'b1;
    @(negedge clk);
    dbg_step = 1'b0;
    chk(ld && !ex && maddr == 9'd0, "R3 fetch after step", {ld, ex, 53'(maddr)}, {2'b10, 53'd0});
    @(negedge clk);
    ok = 1;
    repeat (10) begin @(negedge clk); if (ld || ex) ok = 0; end
    chk(ok && pc == 9'd1, "R3 one instruction per step", {ok, 63'(pc)}, {1'b1, 63'd1});
    dbg_step = 1'b1;
    @(negedge clk);
    dbg_step = 1'b0;
    wait_halt(9'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule